// File: doc/BRIEF.md
# Serial Flash Sector Protection Unit

This block keeps the write-protection state of a serial NOR flash whose array is split into sixteen 64-Kbyte physical sectors. It holds one protection bit per sector and a single lock bit that is visible as bit 7 of the status register. A command front end hands it one decoded request at a time. For each request the block returns a verdict one clock later, and for a protection read it also returns the protection byte. Program and erase engines use the verdict to decide whether to start. The verdict also tells the front end when to drop its write enable latch.

Writes to the protection state are guarded in two layers. A write-status request that sets the lock bit freezes the per-sector bits against single-sector protect and unprotect requests. While the lock bit is set, an active-low write-protect pin held low also freezes the lock bit itself. A write-status request can protect or unprotect every sector in one step. It does so only when the lock bit was clear before the write. The choice between protect and unprotect comes from the written data bits 5:2.

Top module: `sector_guard`

## Requirements
- R1: The sector index of a request is address bits 19:16. Address bits 23:20 and 15:0 have no effect on which sector is selected.
- R2: After reset every sector bit is set (protected) and the lock bit `lock_out` is 0.
- R3: A check request (kind 0) is allowed exactly when the addressed sector bit is 0. It changes no state and does not pulse `wel_clear`.
- R4: A protection read (kind 4) is always allowed and returns FFh for a protected sector and 00h for an unprotected one. Every other response returns 00h on `resp_data`.
- R5: A protect (kind 1) or unprotect (kind 2) request with `wel_in`=1 and the lock bit clear sets or clears only the addressed sector bit. The response is allowed and `wel_clear` pulses.
- R6: A protect or unprotect request with `wel_in`=1 while the lock bit is set changes no sector bit. The response is denied and `wel_clear` pulses.
- R7: A protect, unprotect or write-status request (kind 3) with `wel_in`=0 changes no state. The response is denied and `wel_clear` stays 0.
- R8: An accepted write-status request loads the lock bit from data bit 7. If the lock bit was 0 before the write, data bits 5:2 = 1111 protect every sector and 0000 unprotect every sector. Any other pattern, or a prior lock bit of 1, leaves the sector bits unchanged.
- R9: Writing FFh with the lock bit clear protects every sector and sets the lock bit in the same request.
- R10: A write-status request while the lock bit is 1 and `wp_n`=0 is denied, changes no state and pulses `wel_clear`. With `wp_n`=1 it is accepted and may clear the lock bit.
- R11: `resp_valid` is high in the cycle after each cycle with `req_valid` high, and low otherwise. Request kinds 5 to 7 are denied, change no state and leave `wel_clear` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 3 | 0 check, 1 protect, 2 unprotect, 3 write status, 4 protection read |
| req_addr | input | 24 | Byte address of the request |
| req_data | input | 8 | Status byte for write-status requests |
| wel_in | input | 1 | Current write enable latch |
| wp_n | input | 1 | Write-protect pin, active low |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_allow | output | 1 | 1 allowed / performed, 0 denied |
| resp_data | output | 8 | Protection byte for protection reads |
| wel_clear | output | 1 | Write enable latch must be cleared |
| lock_out | output | 1 | Current lock bit (status bit 7) |

## Verification
The bench builds the block with its default parameters: a 24-bit address and a 4-bit sector index at bit 16, which gives sixteen sectors. Because there are only sixteen sectors, the bench can read every sector back after every state change. It applies all 256 write-status data bytes, each from a prior lock bit of 0 and a varied sector pattern, and sweeps the write enable, write-protect pin and lock bit combinations for each request kind. The address patterns put varying values in the undecoded upper and lower bits.

// File: rtl/sprot_pkg.sv
package sprot_pkg;

  typedef enum logic [2:0] {
    K_CHECK  = 3'd0,
    K_PROT   = 3'd1,
    K_UNPROT = 3'd2,
    K_WRSTAT = 3'd3,
    K_RDPROT = 3'd4
  } req_kind_e;

  // Bulk action picked by written status bits 5:2: {protect_all, unprotect_all}
  function automatic logic [1:0] bulk_sel(input logic [7:0] d);
    if (d[5:2] == 4'b1111)      bulk_sel = 2'b10;
    else if (d[5:2] == 4'b0000) bulk_sel = 2'b01;
    else                        bulk_sel = 2'b00;
  endfunction

endpackage

// File: rtl/sprot_decode.sv
module sprot_decode
  import sprot_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SECT_LSB = 16,
  parameter int SECT_W   = 4,
  localparam int NSECT   = 1 << SECT_W
) (
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              wel_in,
  input  logic              wp_n,
  input  logic              lock_q,
  input  logic [NSECT-1:0]  prot_bits,
  output logic [SECT_W-1:0] sect_idx,
  output logic              set_one,
  output logic              clr_one,
  output logic              set_all,
  output logic              clr_all,
  output logic              lock_we,
  output logic              lock_d,
  output logic              grant,
  output logic              wel_clr,
  output logic [7:0]        rd_byte
);

  function automatic logic [SECT_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    sector_of = a[SECT_LSB +: SECT_W];
  endfunction

  assign sect_idx = sector_of(req_addr);
  assign lock_d   = req_data[7];

  logic hw_frozen;
  assign hw_frozen = lock_q && !wp_n;

  always_comb begin
    set_one = 1'b0;
    clr_one = 1'b0;
    set_all = 1'b0;
    clr_all = 1'b0;
    lock_we = 1'b0;
    grant   = 1'b0;
    wel_clr = 1'b0;
    rd_byte = 8'h00;
    if (req_valid) begin
      case (req_kind)
        K_CHECK: grant = !prot_bits[sect_idx];
        K_PROT, K_UNPROT: begin
          if (wel_in) begin
            wel_clr = 1'b1;
            if (!lock_q) begin
              grant   = 1'b1;
              set_one = (req_kind == K_PROT);
              clr_one = (req_kind == K_UNPROT);
            end
          end
        end
        K_WRSTAT: begin
          if (wel_in) begin
            wel_clr = 1'b1;
            if (!hw_frozen) begin
              grant   = 1'b1;
              lock_we = 1'b1;
              if (!lock_q) {set_all, clr_all} = bulk_sel(req_data);
            end
          end
        end
        K_RDPROT: begin
          grant   = 1'b1;
          rd_byte = {8{prot_bits[sect_idx]}};
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sprot_bank.sv
module sprot_bank #(
  parameter int SECT_W = 4,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SECT_W-1:0] sect_idx,
  input  logic              set_one,
  input  logic              clr_one,
  input  logic              set_all,
  input  logic              clr_all,
  output logic [NSECT-1:0]  prot_bits
);

  for (genvar g = 0; g < NSECT; g++) begin : g_sect
    logic hit;
    assign hit = (sect_idx == SECT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          prot_bits[g] <= 1'b1;
      else if (set_all || (set_one && hit)) prot_bits[g] <= 1'b1;
      else if (clr_all || (clr_one && hit)) prot_bits[g] <= 1'b0;
    end
  end

  // R8
  one_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_one, clr_one, set_all, clr_all}));

  // R5
  single_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_one && !set_all) |=> ($countones(prot_bits ^ $past(prot_bits)) <= 1));

endmodule

// File: rtl/sprot_lock.sv
module sprot_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_we,
  input  logic lock_d,
  input  logic wp_n,
  output logic lock_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b0;
    else if (lock_we) lock_q <= lock_d;
  end

  // R10
  hw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !wp_n) |=> lock_q);

endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sprot_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SECT_LSB = 16,
  parameter int SECT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              wel_in,
  input  logic              wp_n,
  output logic              resp_valid,
  output logic              resp_allow,
  output logic [7:0]        resp_data,
  output logic              wel_clear,
  output logic              lock_out
);

  localparam int NSECT = 1 << SECT_W;

  logic [NSECT-1:0]  prot_bits;
  logic [SECT_W-1:0] sect_idx;
  logic set_one, clr_one, set_all, clr_all;
  logic lock_we, lock_d, lock_q;
  logic grant, wel_clr;
  logic [7:0] rd_byte;

  sprot_decode #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .SECT_W(SECT_W)) u_decode (
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_data(req_data), .wel_in(wel_in), .wp_n(wp_n), .lock_q(lock_q),
    .prot_bits(prot_bits), .sect_idx(sect_idx), .set_one(set_one),
    .clr_one(clr_one), .set_all(set_all), .clr_all(clr_all),
    .lock_we(lock_we), .lock_d(lock_d), .grant(grant), .wel_clr(wel_clr),
    .rd_byte(rd_byte)
  );

  sprot_bank #(.SECT_W(SECT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .sect_idx(sect_idx), .set_one(set_one),
    .clr_one(clr_one), .set_all(set_all), .clr_all(clr_all),
    .prot_bits(prot_bits)
  );

  sprot_lock u_lock (
    .clk(clk), .rst_n(rst_n), .lock_we(lock_we), .lock_d(lock_d),
    .wp_n(wp_n), .lock_q(lock_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
      resp_data  <= 8'h00;
      wel_clear  <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_allow <= grant;
      resp_data  <= rd_byte;
      wel_clear  <= wel_clr;
    end
  end

  assign lock_out = lock_q;

  // R3
  deny_protected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == K_CHECK && prot_bits[req_addr[SECT_LSB +: SECT_W]])
      |=> (resp_valid && !resp_allow));

  // R6
  locked_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && wel_in && lock_q && (req_kind == K_PROT || req_kind == K_UNPROT))
      |=> ($stable(prot_bits) && wel_clear && !resp_allow));

  // R7
  no_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !wel_in && (req_kind == K_PROT || req_kind == K_UNPROT || req_kind == K_WRSTAT))
      |=> ($stable(prot_bits) && $stable(lock_q) && !wel_clear && !resp_allow));

  // R10
  hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == K_WRSTAT && lock_q && !wp_n)
      |=> ($stable(prot_bits) && lock_q && !resp_allow));

  // R4
  rd_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_data == 8'h00 || resp_data == 8'hFF));

  // R11
  resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  // R11
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

endmodule

// File: tb/test_sector_guard.sv
module test_sector_guard;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic [23:0] req_addr = 24'h0;
  logic [7:0] req_data = 8'h00;
  logic wel_in = 1'b0;
  logic wp_n = 1'b1;
  logic resp_valid, resp_allow, wel_clear, lock_out;
  logic [7:0] resp_data;

  int n_vec = 0;
  int n_bad = 0;

  logic [15:0] m_prot;
  logic        m_lock;

  always #2.5 clk = ~clk;

  sector_guard i_sector_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_data(req_data), .wel_in(wel_in), .wp_n(wp_n),
    .resp_valid(resp_valid), .resp_allow(resp_allow), .resp_data(resp_data),
    .wel_clear(wel_clear), .lock_out(lock_out)
  );

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Builds an address for sector s with varied undecoded bits (R1)
  function automatic logic [23:0] mk_addr(input int s, input int j);
    return {4'((j * 7 + 3) % 16), 4'(s), 16'((s * 4099 + j * 257) % 65536)};
  endfunction

  task automatic send(input logic [2:0] k, input logic [23:0] a, input logic [7:0] d,
                      input logic w, input logic wp, input string tag);
    logic e_allow, e_wclr;
    logic [7:0] e_data;
    int idx;
    idx = int'(a[19:16]);
    e_allow = 1'b0; e_wclr = 1'b0; e_data = 8'h00;
    @(negedge clk);
    req_kind = k; req_addr = a; req_data = d; wel_in = w; wp_n = wp; req_valid = 1'b1;
    case (k)
      3'd0: e_allow = (m_prot[idx] == 1'b0);
      3'd1, 3'd2: if (w) begin
        e_wclr = 1'b1;
        if (m_lock == 1'b0) begin m_prot[idx] = (k == 3'd1); e_allow = 1'b1; end
      end
      3'd3: if (w) begin
        e_wclr = 1'b1;
        if (!(m_lock && !wp)) begin
          if (m_lock == 1'b0) begin
            if (d[5] & d[4] & d[3] & d[2]) m_prot = 16'hFFFF;
            else if (!(d[5] | d[4] | d[3] | d[2])) m_prot = 16'h0000;
          end
          m_lock = d[7];
          e_allow = 1'b1;
        end
      end
      3'd4: begin e_allow = 1'b1; e_data = m_prot[idx] ? 8'hFF : 8'h00; end
      default: ;
    endcase
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, "resp_valid", {7'd0, resp_valid}, 8'd1);
    chk(tag, "allow", {7'd0, resp_allow}, {7'd0, e_allow});
    chk(tag, "wel_clear", {7'd0, wel_clear}, {7'd0, e_wclr});
    chk(tag, "data", resp_data, e_data);
    chk(tag, "lock", {7'd0, lock_out}, {7'd0, m_lock});
  endtask

  task automatic read_all(input string tag, input int j);
    for (int s = 0; s < 16; s++) send(3'd4, mk_addr(s, j), 8'h00, 1'b0, 1'b1, tag);
  endtask

  initial begin
    repeat (20000 * 10) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    m_prot = 16'hFFFF;
    m_lock = 1'b0;
    repeat (4) @(negedge clk);
    // R2: reset state at the ports
    chk("R2", "resp_valid", {7'd0, resp_valid}, 8'd0);
    chk("R2", "lock", {7'd0, lock_out}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "idle resp_valid", {7'd0, resp_valid}, 8'd0);
    read_all("R2", 0);

    // R3: check requests while all protected, varied upper bits (R1)
    for (int j = 0; j < 3; j++)
      for (int s = 0; s < 16; s++) send(3'd0, mk_addr(s, j), 8'h00, 1'b0, 1'b1, "R3");

    // R5: unprotect even sectors, protect back sector 4
    for (int s = 0; s < 16; s += 2) send(3'd2, mk_addr(s, s), 8'h00, 1'b1, 1'b1, "R5");
    send(3'd1, mk_addr(4, 9), 8'h00, 1'b1, 1'b1, "R5");
    for (int s = 0; s < 16; s++) send(3'd0, mk_addr(s, 5), 8'h00, 1'b0, 1'b1, "R1");
    read_all("R4", 2);

    // R7: no write enable latch
    for (int s = 0; s < 16; s++) begin
      send(3'd1, mk_addr(s, 1), 8'h00, 1'b0, 1'b1, "R7");
      send(3'd2, mk_addr(s, 2), 8'h00, 1'b0, 1'b0, "R7");
    end
    send(3'd3, 24'h0, 8'hFF, 1'b0, 1'b1, "R7");
    read_all("R7", 3);

    // R11: undefined request kinds
    for (int k = 5; k < 8; k++) send(3'(k), mk_addr(k, k), 8'hFF, 1'b1, 1'b1, "R11");
    read_all("R11", 4);

    // R9: FFh gives bulk protect plus lock
    send(3'd3, 24'h0, 8'hFF, 1'b1, 1'b1, "R9");
    read_all("R9", 5);

    // R6: locked, single-sector requests refused
    for (int s = 0; s < 16; s++) send(3'd2, mk_addr(s, 6), 8'h00, 1'b1, 1'b1, "R6");
    read_all("R6", 6);

    // R10: hardware lock, then release with pin high
    send(3'd3, 24'h0, 8'h00, 1'b1, 1'b0, "R10");
    send(3'd3, 24'h0, 8'h7C, 1'b1, 1'b0, "R10");
    read_all("R10", 7);
    send(3'd3, 24'h0, 8'h00, 1'b1, 1'b1, "R10");
    read_all("R10", 8);

    // R8: every status byte from a clear lock bit and a varied sector pattern
    for (int d = 0; d < 256; d++) begin
      if (m_lock) send(3'd3, 24'h0, 8'h00, 1'b1, 1'b1, "R8");
      send(3'd2, mk_addr(d % 16, d), 8'h00, 1'b1, 1'b1, "R8");
      send(3'd1, mk_addr((d * 5) % 16, d), 8'h00, 1'b1, 1'b1, "R8");
      send(3'd3, mk_addr(d % 16, d), 8'(d), 1'b1, (d % 3) != 0, "R8");
      read_all("R8", d);
      // prior lock 1 with pin high: bulk bits must be ignored
      if (m_lock) begin
        send(3'd3, 24'h0, 8'(d ^ 8'h80), 1'b1, 1'b1, "R8");
        read_all("R8", d + 1);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule